// File: doc/BRIEF.md
# Compressed Block Segment Fetcher

This block reads one compressed memory block by first reading its header. Given a block index, it forms the header address from a base address and the index, reads the header as a short burst, and decodes it. There are two outcomes. The header may describe between one and four scattered 256-byte segments, and the block then reads each segment with a separate burst. The header may instead carry a small immediate-data payload, and the block then sends that payload without reading any segment.

The fetched compressed bytes go to a downstream decompressor over a valid/ready stream. The final beat is tagged. A header that cannot be decoded raises an error pulse, and the block then goes idle without output. The memory side is one read-request channel and one read-response channel, each with a valid/ready handshake. While in the segment phase, response beats pass straight through to the output, so consumer backpressure stalls memory and no beat is lost.

Top module: `seg_fetch`

## Requirements
- R1: An accepted index `i` produces exactly one header read request with address `hdr_base + 32*i` and a length of 4 beats.
- R2: A valid header with segment count `n` (1 to 4) produces `n` segment read requests after the header read. They use pointers 0 to `n-1` in that order, and each has a length of 32 beats. Header beat layout (64-bit beats): beat 0 has bits [2:0] = segment count and bit [3] = immediate flag. Beat 2 is {pointer1, pointer0} and beat 3 is {pointer3, pointer2}, with the low pointer in bits [31:0]. Beat 1 is unused.
- R3: In segment mode, the output beats equal the memory response beats, in the same order. `out_last` is set on the final beat of the final segment and on no other beat.
- R4: When the immediate flag is set, the count field is ignored and no segment request is issued. Exactly two beats are output: header beat 2, then header beat 3 with `out_last` set.
- R5: A non-immediate header with count 0, 5, 6 or 7 produces a one-cycle `err` pulse. It produces no output beat and no segment request, and the block then accepts a new index.
- R6: A null (zero) pointer at a position below the count is an error, as in R5. Null pointers at or above the count are ignored.
- R7: When `out_ready` is low, the offered output beat stays valid and unchanged, and no beat is dropped or duplicated.
- R8: A memory request that is not accepted stays valid with the same address and length.
- R9: `req_ready` is high only when the block is idle. After reset the block is idle, and `out_valid`, `mem_req_valid` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_base | input | 32 | Header table base byte address |
| req_valid | input | 1 | Block index offered |
| req_ready | output | 1 | Block idle, index accepted |
| req_index | input | 16 | Real block index |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_beats | output | 6 | Burst length in beats |
| mem_rsp_valid | input | 1 | Read data beat valid |
| mem_rsp_ready | output | 1 | Read data beat taken |
| mem_rsp_data | input | 64 | Read data beat |
| out_valid | output | 1 | Compressed beat valid |
| out_ready | input | 1 | Decompressor accepts beat |
| out_data | output | 64 | Compressed beat |
| out_last | output | 1 | Final beat of the block |
| err | output | 1 | Malformed header pulse |

## Verification
An index taken at a clock edge puts its header request on the port in the next cycle. The decode cycle comes one cycle after the fourth header beat, and any error pulse appears in that decode cycle. Immediate beats start in the cycle after decode. In the segment phase each output beat appears in the same cycle as its memory beat, and the next segment request follows one cycle after the last beat of the previous segment. The bench does not predict exact cycle numbers, because its memory model and consumer stall in a pseudo-random way. It logs every request, response and output handshake at the clock edge where it occurs. After the block is idle again, it compares those logged sequences with the expected sequences and checks for any change in an offered beat while that beat was held.

// File: rtl/seg_fetch.sv
module seg_fetch #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 16,
  parameter int SEG_BYTES = 256,
  localparam int DATA_W    = 2 * ADDR_W,
  localparam int SEG_BEATS = SEG_BYTES / (DATA_W / 8),
  localparam int LEN_W     = $clog2(SEG_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hdr_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_index,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LEN_W-1:0]  mem_req_beats,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              err
);
  localparam int HDR_BEATS = 4;
  localparam int HDR_SH    = $clog2(HDR_BEATS * DATA_W / 8);

  typedef enum logic [2:0] {S_IDLE, S_HREQ, S_HDAT, S_DEC, S_IMM, S_SREQ, S_SDAT} st_t;
  st_t state;

  logic [IDX_W-1:0]  idx_q;
  logic [2:0]        cnt_q;
  logic              imm_q;
  logic [DATA_W-1:0] w2_q, w3_q;
  logic [1:0]        hbeat_q, seg_q;
  logic [LEN_W-1:0]  beat_q;
  logic [ADDR_W-1:0] ptrs [4];
  logic              nul_hit, bad, seg_end, last_seg;

  assign ptrs[0] = w2_q[ADDR_W-1:0];
  assign ptrs[1] = w2_q[DATA_W-1:ADDR_W];
  assign ptrs[2] = w3_q[ADDR_W-1:0];
  assign ptrs[3] = w3_q[DATA_W-1:ADDR_W];

  always_comb begin
    nul_hit = 1'b0;
    for (int k = 0; k < 4; k++)
      if (3'(k) < cnt_q && ptrs[k] == '0) nul_hit = 1'b1;
  end

  assign bad      = !imm_q && (cnt_q == 3'd0 || cnt_q > 3'd4 || nul_hit);
  assign last_seg = ({1'b0, seg_q} + 3'd1) == cnt_q;
  assign seg_end  = beat_q == LEN_W'(SEG_BEATS - 1);

  assign req_ready     = state == S_IDLE;
  assign err           = state == S_DEC && bad;
  assign mem_req_valid = state == S_HREQ || state == S_SREQ;
  assign mem_req_addr  = (state == S_HREQ) ? hdr_base + (ADDR_W'(idx_q) << HDR_SH) : ptrs[seg_q];
  assign mem_req_beats = (state == S_HREQ) ? LEN_W'(HDR_BEATS) : LEN_W'(SEG_BEATS);
  assign mem_rsp_ready = state == S_HDAT || (state == S_SDAT && out_ready);
  assign out_valid     = state == S_IMM || (state == S_SDAT && mem_rsp_valid);
  assign out_data      = (state == S_IMM) ? (hbeat_q[0] ? w3_q : w2_q) : mem_rsp_data;
  assign out_last      = (state == S_IMM) ? hbeat_q[0]
                       : (state == S_SDAT && mem_rsp_valid && seg_end && last_seg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      imm_q   <= 1'b0;
      w2_q    <= '0;
      w3_q    <= '0;
      hbeat_q <= '0;
      seg_q   <= '0;
      beat_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          idx_q <= req_index;
          state <= S_HREQ;
        end
        S_HREQ: if (mem_req_ready) begin
          hbeat_q <= '0;
          state   <= S_HDAT;
        end
        S_HDAT: if (mem_rsp_valid) begin
          hbeat_q <= hbeat_q + 2'd1;
          case (hbeat_q)
            2'd0: begin cnt_q <= mem_rsp_data[2:0]; imm_q <= mem_rsp_data[3]; end
            2'd2: w2_q <= mem_rsp_data;
            2'd3: begin w3_q <= mem_rsp_data; state <= S_DEC; end
            default: ;
          endcase
        end
        S_DEC: begin
          hbeat_q <= '0;
          seg_q   <= '0;
          if (imm_q)    state <= S_IMM;
          else if (bad) state <= S_IDLE;
          else          state <= S_SREQ;
        end
        S_IMM: if (out_ready) begin
          hbeat_q <= hbeat_q + 2'd1;
          if (hbeat_q[0]) state <= S_IDLE;
        end
        S_SREQ: if (mem_req_ready) begin
          beat_q <= '0;
          state  <= S_SDAT;
        end
        S_SDAT: if (mem_rsp_valid && out_ready) begin
          beat_q <= beat_q + 1'b1;
          if (seg_end) begin
            seg_q <= seg_q + 2'd1;
            state <= last_seg ? S_IDLE : S_SREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_beats));

  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r3_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r6_seg_nonnull: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_beats == LEN_W'(SEG_BEATS) |-> mem_req_addr != '0);

  a_r5_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> req_ready && !out_valid);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err, out_valid, mem_req_valid}));
endmodule

// File: tb/seg_fetch_test.sv
module seg_fetch_test;
  localparam logic [31:0] BASE = 32'h0000_4000;
  localparam int NH = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [15:0] req_index = '0;
  logic        req_ready;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic [5:0]  mem_req_beats;
  logic        mem_rsp_valid, mem_rsp_ready;
  logic [63:0] mem_rsp_data;
  logic        out_valid, out_ready, out_last, err;
  logic [63:0] out_data;

  seg_fetch uut (
    .clk(clk), .rst_n(rst_n), .hdr_base(BASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_beats(mem_req_beats),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .err(err));

  logic [2:0]  hcnt [NH];
  logic        himm [NH];
  logic [31:0] hp   [NH][4];

  int checks = 0, fails = 0;
  int cycles = 0;
  bit stall_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] resp(input logic [31:0] a, input int k);
    int i;
    if (a >= BASE && a < BASE + 32'(NH * 32)) begin
      i = int'((a - BASE) >> 5);
      case (k)
        0: return {60'd0, himm[i], hcnt[i]};
        2: return {hp[i][1], hp[i][0]};
        3: return {hp[i][3], hp[i][2]};
        default: return 64'd0;
      endcase
    end
    return {a, 32'(k)};
  endfunction

  // memory model and consumer
  logic [7:0]  lf = 8'h5b;
  logic        busy = 1'b0;
  logic [31:0] m_addr = '0;
  logic [5:0]  m_len = '0;
  int          m_cnt = 0;
  initial begin mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; out_ready = 1'b1; end

  always @(posedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    out_ready <= !stall_en || lf[2];
    if (!rst_n) begin
      busy <= 1'b0; mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0;
    end else if (!busy) begin
      if (mem_req_valid && mem_req_ready) begin
        busy <= 1'b1; m_addr <= mem_req_addr; m_len <= mem_req_beats; m_cnt <= 0;
        mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0;
      end else mem_req_ready <= !stall_en || lf[1];
    end else begin
      if (mem_rsp_valid && mem_rsp_ready) begin
        if (m_cnt + 1 == int'(m_len)) begin busy <= 1'b0; mem_rsp_valid <= 1'b0; end
        else begin
          m_cnt <= m_cnt + 1;
          mem_rsp_valid <= !stall_en || lf[5] || lf[1];
          mem_rsp_data <= resp(m_addr, m_cnt + 1);
        end
      end else if (!mem_rsp_valid) begin
        mem_rsp_valid <= !stall_en || lf[5] || lf[1];
        mem_rsp_data <= resp(m_addr, m_cnt);
      end
    end
  end

  // handshake logs
  logic [31:0] rq_a [8];
  logic [5:0]  rq_l [8];
  logic [63:0] ob_d [160];
  logic        ob_l [160];
  int nreq = 0, nout = 0, nerr = 0, hold_bad = 0, rq_bad = 0;
  logic pv = 1'b0, pr = 1'b0, qv = 1'b0, qr = 1'b0;
  logic [63:0] pd = '0;
  logic [31:0] qa = '0;

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready && nreq < 8) begin rq_a[nreq] = mem_req_addr; rq_l[nreq] = mem_req_beats; nreq++; end
      if (out_valid && out_ready && nout < 160) begin ob_d[nout] = out_data; ob_l[nout] = out_last; nout++; end
      if (err) nerr++;
      if (pv && !pr && !(out_valid && out_data == pd)) hold_bad++;
      if (qv && !qr && !(mem_req_valid && mem_req_addr == qa)) rq_bad++;
    end
    pv = out_valid; pr = out_ready; pd = out_data;
    qv = mem_req_valid; qr = mem_req_ready; qa = mem_req_addr;
  end

  task automatic run_job(input int idx);
    bit bad, tmo;
    int n, e, w;
    nreq = 0; nout = 0; nerr = 0;
    @(negedge clk);
    req_valid = 1'b1; req_index = 16'(idx);
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!req_ready && w < 3000) begin @(negedge clk); w++; end
    tmo = w >= 3000;
    chk(!tmo, "R9 job returns idle", 64'(w), 64'd0);
    // R1 header request
    chk(nreq >= 1 && rq_a[0] == BASE + 32'(idx * 32) && rq_l[0] == 6'd4, "R1 header addr/len",
        {rq_l[0], rq_a[0]}, {6'd4, BASE + 32'(idx * 32)});
    n = int'(hcnt[idx]);
    bad = 1'b0;
    if (!himm[idx]) begin
      if (n == 0 || n > 4) bad = 1'b1;
      for (int k = 0; k < 4; k++) if (k < n && hp[idx][k] == 0) bad = 1'b1;
    end
    if (himm[idx]) begin
      chk(nreq == 1 && nerr == 0, "R4 no segment read", 64'(nreq), 64'd1);
      chk(nout == 2, "R4 beat count", 64'(nout), 64'd2);
      chk(ob_d[0] == {hp[idx][1], hp[idx][0]} && !ob_l[0], "R4 first beat", ob_d[0], {hp[idx][1], hp[idx][0]});
      chk(ob_d[1] == {hp[idx][3], hp[idx][2]} && ob_l[1], "R4 second beat last", ob_d[1], {hp[idx][3], hp[idx][2]});
    end else if (bad) begin
      chk(nerr == 1, "R5/R6 error pulse", 64'(nerr), 64'd1);
      chk(nout == 0 && nreq == 1, "R5/R6 no output or segment read", 64'(nout + nreq), 64'd1);
    end else begin
      chk(nerr == 0, "R6 no error", 64'(nerr), 64'd0);
      chk(nreq == n + 1, "R2 request count", 64'(nreq), 64'(n + 1));
      for (int k = 0; k < n && k + 1 < nreq; k++)
        chk(rq_a[k+1] == hp[idx][k] && rq_l[k+1] == 6'd32, "R2 segment order", 64'(rq_a[k+1]), 64'(hp[idx][k]));
      chk(nout == 32 * n, "R3 beat count", 64'(nout), 64'(32 * n));
      e = 0;
      for (int k = 0; k < n; k++)
        for (int j = 0; j < 32; j++) begin
          w = k * 32 + j;
          if (w < nout && (ob_d[w] != {hp[idx][k], 32'(j)} || ob_l[w] != (w == 32 * n - 1))) e++;
        end
      chk(e == 0, "R3 beat data and last", 64'(e), 64'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      hcnt[i] = 3'(i + 1); himm[i] = 1'b0;
      for (int k = 0; k < 4; k++) hp[i][k] = 32'h0010_0000 + 32'(i * 32'h1000) + 32'(k * 32'h300) + 32'((3 - k) * 32'h40000);
    end
    for (int i = 4; i < NH; i++) begin
      himm[i] = 1'b0;
      for (int k = 0; k < 4; k++) hp[i][k] = 32'h0020_0000 + 32'(i * 32'h1000) + 32'(k * 32'h100);
    end
    hcnt[4] = 3'd0; hcnt[5] = 3'd5; hcnt[6] = 3'd7;
    hcnt[7] = 3'd3; himm[7] = 1'b1; hp[7][0] = 32'hdead_0001; hp[7][3] = 32'h0;
    hcnt[8] = 3'd3; hp[8][1] = 32'h0;
    hcnt[9] = 3'd2; hp[9][2] = 32'h0; hp[9][3] = 32'h0;
    hcnt[10] = 3'd4; hp[10][3] = 32'h0;
    hcnt[11] = 3'd0; himm[11] = 1'b1; hp[11][1] = 32'h0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !out_valid && !mem_req_valid && !err, "R9 reset state",
        {60'd0, req_ready, out_valid, mem_req_valid, err}, 64'h8);
    for (int pass = 0; pass < 2; pass++) begin
      stall_en = pass[0];
      for (int i = 0; i < NH; i++) run_job(i);
    end
    chk(hold_bad == 0, "R7 held output beat stable", 64'(hold_bad), 64'd0);
    chk(rq_bad == 0, "R8 held request stable", 64'(rq_bad), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule